// File: doc/BRIEF.md
# Stack Frame Release Sequencer

This block carries out the multi-register pop that ends a function. It is told the caller's stack pointer, a 5-bit frame-size immediate, a 12-bit register-select mask and, optionally, a register index that holds a return address. It first releases the local frame by raising the pointer by four times the immediate. It then walks the mask and issues one word read per selected register. Each returned word goes to the register file, and the pointer moves up by four after every read.

When the jump form is requested, the block reads the named register once all loads are complete and presents its value as the new program counter. The finished pointer value comes out with a one-cycle done strobe. A new request is taken only while the block is idle. Every memory read may be stretched by any number of wait cycles.

Top module: `frame_pop_seq`

## Requirements
- R1: `startReady` is high only while idle; `startValid` is taken only in a cycle where `startReady` is high, and is ignored during a sequence; `startReady` is high again in the cycle after `done`.
- R2: The first word read uses address `spIn + (zero-extended frameImm << 2)`.
- R3: Mask bits are serviced lowest index first; bit i writes register 20+i, and `rfWrData` is the word returned for that read.
- R4: Each read after the first uses the address of the previous read plus 4.
- R5: `rfWrEn` pulses only in a cycle where a read is requested and its response is valid, exactly once per set mask bit.
- R6: While a read waits for its response, `memReqValid` stays high and `memReqAddr` holds.
- R7: With `jumpEn` set, `pcLoadValid` pulses together with `done`, and `pcLoadAddr` equals the value of register `jumpIdx` after all loads (a register loaded by this sequence gives its new value); with `jumpEn` clear, `pcLoadValid` never rises.
- R8: With responses in the cycle of the request, a sequence occupies N+1 cycles without the jump and N+3 with it, counted from the cycle after acceptance through the `done` cycle; each wait cycle adds one.
- R9: `done` comes with `spWrEn`, and `spWrData = spIn + 4*frameImm + 4*N`.
- R10: An empty mask issues no read and reaches `done` in 1 cycle, or in 3 cycles with the jump.
- R11: After reset, `startReady` is high and `memReqValid`, `rfWrEn`, `pcLoadValid`, `spWrEn` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Request to start a sequence |
| startReady | output | 1 | Idle; request is taken this cycle |
| frameImm | input | 5 | Frame size in words |
| regMask | input | 12 | Register-select mask, bit i selects register 20+i |
| jumpEn | input | 1 | Finish with an indirect jump |
| jumpIdx | input | 5 | Register holding the jump target |
| spIn | input | 32 | Stack pointer at start |
| memReqValid | output | 1 | Word read request |
| memReqAddr | output | 32 | Read address |
| memRespValid | input | 1 | Read data valid this cycle |
| memRespData | input | 32 | Read data |
| rfWrEn | output | 1 | Register file write strobe |
| rfWrIdx | output | 5 | Register file write index |
| rfWrData | output | 32 | Register file write data |
| rfRdIdx | output | 5 | Register file read index (jump target) |
| rfRdData | input | 32 | Register file read data |
| pcLoadValid | output | 1 | Load program counter |
| pcLoadAddr | output | 32 | New program counter |
| spWrEn | output | 1 | Write back final stack pointer |
| spWrData | output | 32 | Final stack pointer |
| done | output | 1 | Last cycle of the sequence |

## Verification
On every cycle the assertions check the following: the register file is written only when a response is present; a stalled read holds its address; successive reads step by four; an idle block issues nothing; a program-counter load comes only with done; and done returns the block to idle. The scenarios show what needs whole-sequence knowledge. These are the starting address after the frame adjustment, the lowest-first order and the bit-to-register mapping, the exact number of writes and cycles, the final pointer, and the jump target when the target register was just reloaded. The scenarios also show that requests arriving mid-sequence are ignored.

// File: rtl/frame_pop_pkg.sv
package frame_pop_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch request operands
    logic adjust;    // add scaled frame size to pointer
    logic loadStep;  // retire one load: pointer += 4, drop mask bit
    logic jumpRead;  // latch jump target from register file
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADJ,
    ST_LOAD,
    ST_JRD,
    ST_JGO
  } seqState_t;

endpackage

// File: rtl/frame_pop_dp.sv
module frame_pop_dp
  import frame_pop_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int MASK_W   = 12,
  parameter int IMM_W    = 5,
  parameter int IDX_W    = 5,
  parameter int REG_BASE = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  logic [XLEN-1:0]   spIn,
  input  logic [IMM_W-1:0]  frameImm,
  input  logic [MASK_W-1:0] regMask,
  input  logic              jumpEn,
  input  logic [IDX_W-1:0]  jumpIdx,
  input  logic [XLEN-1:0]   memRespData,
  input  logic [XLEN-1:0]   rfRdData,
  output logic              pendEmpty,
  output logic              lastPend,
  output logic              jumpLatched,
  output logic [XLEN-1:0]   memReqAddr,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [XLEN-1:0]   rfWrData,
  output logic [IDX_W-1:0]  rfRdIdx,
  output logic [XLEN-1:0]   pcTarget,
  output logic [XLEN-1:0]   spNext
);

  localparam int BIT_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

  logic [XLEN-1:0]   spQ;
  logic [IMM_W-1:0]  immQ;
  logic [MASK_W-1:0] pendQ;
  logic [IDX_W-1:0]  jIdxQ;
  logic              jEnQ;
  logic [XLEN-1:0]   targetQ;
  logic [BIT_W-1:0]  curBit;
  logic [MASK_W-1:0] pendCleared;
  logic [IDX_W-1:0]  regTable [MASK_W];

  // Fixed mask-bit to register mapping
  for (genvar g = 0; g < MASK_W; g++) begin : gRegMap
    assign regTable[g] = IDX_W'(REG_BASE + g);
  end

  // Lowest pending bit
  always_comb begin
    curBit = '0;
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (pendQ[i]) curBit = BIT_W'(i);
    end
  end

  assign pendCleared = pendQ & (pendQ - MASK_W'(1));
  assign pendEmpty   = (pendQ == '0);
  assign lastPend    = !pendEmpty && (pendCleared == '0);

  always_comb begin
    spNext = spQ;
    if (ctl.adjust)        spNext = spQ + XLEN'({immQ, 2'b00});
    else if (ctl.loadStep) spNext = spQ + WORD_BYTES;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spQ     <= '0;
      immQ    <= '0;
      pendQ   <= '0;
      jIdxQ   <= '0;
      jEnQ    <= 1'b0;
      targetQ <= '0;
    end else begin
      if (ctl.capture) begin
        spQ   <= spIn;
        immQ  <= frameImm;
        pendQ <= regMask;
        jIdxQ <= jumpIdx;
        jEnQ  <= jumpEn;
      end else begin
        spQ <= spNext;
        if (ctl.loadStep) pendQ <= pendCleared;
      end
      if (ctl.jumpRead) targetQ <= rfRdData;
    end
  end

  assign jumpLatched = jEnQ;
  assign memReqAddr  = spQ;
  assign rfWrIdx     = regTable[curBit];
  assign rfWrData    = memRespData;
  assign rfRdIdx     = jIdxQ;
  assign pcTarget    = targetQ;

endmodule

// File: rtl/frame_pop_ctrl.sv
module frame_pop_ctrl
  import frame_pop_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   startValid,
  input  logic   pendEmpty,
  input  logic   lastPend,
  input  logic   jumpLatched,
  input  logic   memRespValid,
  output dpCtl_t ctl,
  output logic   startReady,
  output logic   memReqValid,
  output logic   pcLoadValid,
  output logic   done
);

  seqState_t stateQ, stateD;

  always_comb begin
    stateD      = stateQ;
    ctl         = '0;
    startReady  = 1'b0;
    memReqValid = 1'b0;
    pcLoadValid = 1'b0;
    done        = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        startReady = 1'b1;
        if (startValid) begin
          ctl.capture = 1'b1;
          stateD      = ST_ADJ;
        end
      end
      ST_ADJ: begin
        ctl.adjust = 1'b1;
        if (!pendEmpty)       stateD = ST_LOAD;
        else if (jumpLatched) stateD = ST_JRD;
        else begin
          done   = 1'b1;
          stateD = ST_IDLE;
        end
      end
      ST_LOAD: begin
        memReqValid = 1'b1;
        if (memRespValid) begin
          ctl.loadStep = 1'b1;
          if (lastPend) begin
            if (jumpLatched) stateD = ST_JRD;
            else begin
              done   = 1'b1;
              stateD = ST_IDLE;
            end
          end
        end
      end
      ST_JRD: begin
        ctl.jumpRead = 1'b1;
        stateD       = ST_JGO;
      end
      ST_JGO: begin
        pcLoadValid = 1'b1;
        done        = 1'b1;
        stateD      = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

endmodule

// File: rtl/frame_pop_seq.sv
module frame_pop_seq
  import frame_pop_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int MASK_W   = 12,
  parameter int IMM_W    = 5,
  parameter int IDX_W    = 5,
  parameter int REG_BASE = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startValid,
  output logic              startReady,
  input  logic [IMM_W-1:0]  frameImm,
  input  logic [MASK_W-1:0] regMask,
  input  logic              jumpEn,
  input  logic [IDX_W-1:0]  jumpIdx,
  input  logic [XLEN-1:0]   spIn,
  output logic              memReqValid,
  output logic [XLEN-1:0]   memReqAddr,
  input  logic              memRespValid,
  input  logic [XLEN-1:0]   memRespData,
  output logic              rfWrEn,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [XLEN-1:0]   rfWrData,
  output logic [IDX_W-1:0]  rfRdIdx,
  input  logic [XLEN-1:0]   rfRdData,
  output logic              pcLoadValid,
  output logic [XLEN-1:0]   pcLoadAddr,
  output logic              spWrEn,
  output logic [XLEN-1:0]   spWrData,
  output logic              done
);

  dpCtl_t ctl;
  logic   pendEmpty;
  logic   lastPend;
  logic   jumpLatched;

  frame_pop_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .startValid   (startValid),
    .pendEmpty    (pendEmpty),
    .lastPend     (lastPend),
    .jumpLatched  (jumpLatched),
    .memRespValid (memRespValid),
    .ctl          (ctl),
    .startReady   (startReady),
    .memReqValid  (memReqValid),
    .pcLoadValid  (pcLoadValid),
    .done         (done)
  );

  frame_pop_dp #(
    .XLEN     (XLEN),
    .MASK_W   (MASK_W),
    .IMM_W    (IMM_W),
    .IDX_W    (IDX_W),
    .REG_BASE (REG_BASE)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .spIn        (spIn),
    .frameImm    (frameImm),
    .regMask     (regMask),
    .jumpEn      (jumpEn),
    .jumpIdx     (jumpIdx),
    .memRespData (memRespData),
    .rfRdData    (rfRdData),
    .pendEmpty   (pendEmpty),
    .lastPend    (lastPend),
    .jumpLatched (jumpLatched),
    .memReqAddr  (memReqAddr),
    .rfWrIdx     (rfWrIdx),
    .rfWrData    (rfWrData),
    .rfRdIdx     (rfRdIdx),
    .pcTarget    (pcLoadAddr),
    .spNext      (spWrData)
  );

  assign rfWrEn = ctl.loadStep;
  assign spWrEn = done;

endmodule

// File: rtl/frame_pop_chk.sv
module frame_pop_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            startReady,
  input logic            memReqValid,
  input logic [XLEN-1:0] memReqAddr,
  input logic            memRespValid,
  input logic            rfWrEn,
  input logic            pcLoadValid,
  input logic            spWrEn,
  input logic            done
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    startReady |-> !memReqValid && !rfWrEn && !pcLoadValid);

  assert_done_to_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> startReady);

  assert_step_four_R4: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid && $past(rfWrEn) |-> memReqAddr == $past(memReqAddr) + XLEN'(4));

  assert_write_needs_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rfWrEn |-> memReqValid && memRespValid);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid && !memRespValid |=> memReqValid && $stable(memReqAddr));

  assert_pc_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pcLoadValid |-> done);

  assert_sp_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spWrEn);

endmodule

bind frame_pop_seq frame_pop_chk #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .startReady   (startReady),
  .memReqValid  (memReqValid),
  .memReqAddr   (memReqAddr),
  .memRespValid (memRespValid),
  .rfWrEn       (rfWrEn),
  .pcLoadValid  (pcLoadValid),
  .spWrEn       (spWrEn),
  .done         (done)
);

// File: tb/tb_frame_pop_seq.sv
`timescale 1ns/1ps
module tb_frame_pop_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startValid = 1'b0;
  logic        startReady;
  logic [4:0]  frameImm = '0;
  logic [11:0] regMask = '0;
  logic        jumpEn = 1'b0;
  logic [4:0]  jumpIdx = '0;
  logic [31:0] spIn = '0;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRespValid = 1'b0;
  logic [31:0] memRespData = '0;
  logic        rfWrEn;
  logic [4:0]  rfWrIdx;
  logic [31:0] rfWrData;
  logic [4:0]  rfRdIdx;
  logic [31:0] rfRdData;
  logic        pcLoadValid;
  logic [31:0] pcLoadAddr;
  logic        spWrEn;
  logic [31:0] spWrData;
  logic        done;

  int checks = 0;
  int errors = 0;
  int waits = 0;
  int waitCnt = 0;
  logic [31:0] rf [32];

  always #2.5 clk = ~clk;

  frame_pop_seq dut (.*);

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  function automatic int nthBit(input logic [11:0] m, input int k);
    int seen = 0;
    for (int b = 0; b < 12; b++) begin
      if (m[b]) begin
        if (seen == k) return b;
        seen++;
      end
    end
    return -1;
  endfunction

  // Memory model with programmable wait cycles
  always @(negedge clk) begin
    if (memReqValid) begin
      if (waitCnt >= waits) begin
        memRespValid <= 1'b1;
        memRespData  <= memWord(memReqAddr);
        waitCnt      <= 0;
      end else begin
        memRespValid <= 1'b0;
        waitCnt      <= waitCnt + 1;
      end
    end else begin
      memRespValid <= 1'b0;
      waitCnt      <= 0;
    end
  end

  // Register file model
  assign rfRdData = rf[rfRdIdx];
  always @(posedge clk) if (rfWrEn) rf[rfWrIdx] <= rfWrData;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [31:0] sp, input logic [4:0] imm, input logic [11:0] m,
                       input logic jEn, input logic [4:0] jIdx, input int w, input bit noisy);
    int n = $countones(m);
    int k = 0;
    int cyc = 0;
    int reqs = 0;
    bit badPc = 0;
    logic [31:0] expAddr;
    logic [31:0] expTarget;
    int expCyc;
    expAddr   = sp + {25'd0, imm, 2'b00};
    expTarget = rf[jIdx];
    expCyc    = 1 + n * (1 + w) + (jEn ? 2 : 0);
    @(negedge clk);
    waits      = w;
    startValid = 1'b1;
    spIn = sp; frameImm = imm; regMask = m; jumpEn = jEn; jumpIdx = jIdx;
    @(posedge clk);
    forever begin
      @(negedge clk); #1;
      cyc++;
      if (cyc == 1) begin
        // Mid-sequence requests with other operands must be ignored (R1)
        if (noisy) begin
          spIn = ~sp; frameImm = ~imm; regMask = ~m; jumpEn = ~jEn; jumpIdx = ~jIdx;
        end else startValid = 1'b0;
      end
      if (memReqValid) reqs++;
      if (memReqValid && !memRespValid)
        check(memReqAddr == expAddr, "R6 stalled address", memReqAddr, expAddr);
      if (rfWrEn) begin
        int b = nthBit(m, k);
        logic [4:0] expIdx = 5'(20 + b);
        check(rfWrIdx == expIdx, "R3 write index", 32'(rfWrIdx), 32'(expIdx));
        check(rfWrData == memWord(expAddr), "R3 write data", rfWrData, memWord(expAddr));
        check(memReqAddr == expAddr, (k == 0) ? "R2 first address" : "R4 next address",
              memReqAddr, expAddr);
        if (expIdx == jIdx) expTarget = memWord(expAddr);
        expAddr += 32'd4;
        k++;
      end
      if (pcLoadValid && !jEn) badPc = 1;
      if (done || cyc > 400) break;
    end
    startValid = 1'b0;
    check(done == 1'b1, "R8 sequence finished", 32'(done), 32'd1);
    check(k == n, "R5 write count", 32'(k), 32'(n));
    check(cyc == expCyc, "R8 cycle count", 32'(cyc), 32'(expCyc));
    check(spWrEn && spWrData == expAddr, "R9 final pointer", spWrData, expAddr);
    if (jEn) begin
      check(pcLoadValid == 1'b1, "R7 pc strobe", 32'(pcLoadValid), 32'd1);
      check(pcLoadAddr == expTarget, "R7 pc target", pcLoadAddr, expTarget);
    end else begin
      check(!badPc, "R7 no pc load", 32'(badPc), 32'd0);
    end
    if (m == '0) begin
      check(reqs == 0, "R10 no read on empty mask", 32'(reqs), 32'd0);
      check(cyc == (jEn ? 3 : 1), "R10 empty mask length", 32'(cyc), jEn ? 32'd3 : 32'd1);
    end
    @(negedge clk); #1;
    check(startReady == 1'b1, "R1 ready after done", 32'(startReady), 32'd1);
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 32'h1000_0000 + i;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R11: reset state
    check(startReady == 1'b1, "R11 ready", 32'(startReady), 32'd1);
    check(!memReqValid && !rfWrEn && !pcLoadValid && !spWrEn && !done, "R11 outputs quiet",
          {27'd0, memReqValid, rfWrEn, pcLoadValid, spWrEn, done}, 32'd0);
    rst_n = 1'b1;
    // Directed corners
    runOp(32'h0000_1000, 5'd0, 12'h000, 1'b0, 5'd0, 0, 0);   // R10 no jump
    runOp(32'h0000_2000, 5'd31, 12'h000, 1'b1, 5'd3, 0, 0);  // R10 with jump
    runOp(32'h0000_3000, 5'd2, 12'hFFF, 1'b1, 5'd31, 3, 1);  // full mask, stalls, R7 reloaded target
    runOp(32'hFFFF_FFF0, 5'd1, 12'h801, 1'b0, 5'd0, 1, 0);   // pointer wrap
    // Sweep of every mask
    for (int m = 0; m < 4096; m++) begin
      logic [11:0] mm = 12'(m);
      runOp(32'h0000_8000 + 32'(m) * 64, mm[4:0] ^ mm[11:7], mm, mm[1] ^ mm[6],
            5'((m * 7) % 32), m % 3, m[0]);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule